// File: doc/BRIEF.md
# Floating-point register stack controller

This block holds the eight-entry register stack of a stack-based floating-point coprocessor. It keeps a 3-bit top-of-stack pointer that wraps modulo eight. Each physical register carries an opaque 80-bit value and a 2-bit tag. Operands are named relative to the pointer: ST(i) is physical register (TOP + i) mod 8. The block does no arithmetic. It moves, tags and frees register contents on command and shows the resulting state.

Commands arrive on one port, qualified by a one-cycle valid strobe. Each command carries an opcode, a relative index, an 80-bit value and a tag. All effects appear together at the next clock edge. A combinational read port returns the value and tag of any ST(i). The packed tag word is always visible. A status word supplied from outside is returned with the current pointer merged into its pointer field, so a reader never sees a stale pointer.

Top module: `fstack_ctrl`

## Requirements
- R1: After reset, TOP is 0, every tag is empty (encoding 2'b11) and every register value is zero.
- R2: The read port returns the value and tag of physical register (TOP + rd_idx) mod 8.
- R3: Opcode 1 (push) first sets TOP to (TOP-1) mod 8. It then writes cmd_data and cmd_tag into the register the new TOP names.
- R4: Opcode 2 (load ST(i)) resolves the physical index of ST(cmd_idx) with the old TOP. It then pushes a copy of that register's value and tag.
- R5: Opcode 3 (pop) sets the tag of ST(0) to empty and sets TOP to (TOP+1) mod 8. Register values are unchanged.
- R6: Opcode 4 (exchange) swaps both the values and the tags of ST(0) and ST(cmd_idx). TOP is unchanged.
- R7: Opcode 5 (free) sets the tag of ST(cmd_idx) to empty and leaves TOP and all values unchanged. Opcode 6 (free then pop) also does that, then pops as in R5, using the same old TOP.
- R8: Opcode 7 sets TOP to (TOP+1) mod 8 and opcode 8 sets TOP to (TOP-1) mod 8. Neither changes any tag or value.
- R9: The tag word places the tag of physical register p at bits [2p+1:2p].
- R10: sw_out equals sw_in with bits [13:11] replaced by the current TOP.
- R11: When cmd_valid is low, or when the opcode is 0 or 10 to 15, no state changes.
- R12: Opcode 9 (re-initialise) sets TOP to 0 and all tags to empty. Register values are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 4 | Command opcode |
| cmd_idx | input | 3 | Relative index i of ST(i) |
| cmd_data | input | 80 | Value written by a push |
| cmd_tag | input | 2 | Tag written by a push |
| rd_idx | input | 3 | Relative index for the read port |
| rd_data | output | 80 | Value of ST(rd_idx) |
| rd_tag | output | 2 | Tag of ST(rd_idx) |
| top | output | 3 | Current top-of-stack pointer |
| tag_word | output | 16 | Packed tags of all physical registers |
| sw_in | input | 16 | Status word to merge |
| sw_out | output | 16 | Status word with TOP merged into bits [13:11] |

## Verification
A wrong pointer shows at the next edge on `top` and on `sw_out`. It also rotates every ST(i) read, so all eight reads through the read port mismatch at once. A wrong tag or value stays hidden until the read port or the tag word reaches that physical register. The bench therefore reads all eight relative slots and the full tag word after every command. Any state error is then caught in the cycle after the command that caused it.

// File: rtl/fstack_pkg.sv
package fstack_pkg;
    localparam logic [3:0] OP_NOP      = 4'd0;
    localparam logic [3:0] OP_PUSH     = 4'd1;
    localparam logic [3:0] OP_PUSH_ST  = 4'd2;
    localparam logic [3:0] OP_POP      = 4'd3;
    localparam logic [3:0] OP_XCHG     = 4'd4;
    localparam logic [3:0] OP_FREE     = 4'd5;
    localparam logic [3:0] OP_FREE_POP = 4'd6;
    localparam logic [3:0] OP_INCP     = 4'd7;
    localparam logic [3:0] OP_DECP     = 4'd8;
    localparam logic [3:0] OP_INIT     = 4'd9;
    localparam logic [1:0] TAG_EMPTY   = 2'b11;
endpackage

// File: rtl/fstack_idx.sv
module fstack_idx #(
    parameter int PW = 3
) (
    input  logic [PW-1:0] base,
    input  logic [PW-1:0] rel,
    output logic [PW-1:0] phys
);
    // modular add: width truncation wraps around the ring
    assign phys = base + rel;
endmodule

// File: rtl/fstack_tagpack.sv
module fstack_tagpack #(
    parameter int NREG = 8,
    parameter int TW   = 2
) (
    input  logic [NREG-1:0][TW-1:0] tags,
    output logic [NREG*TW-1:0]      word
);
    for (genvar p = 0; p < NREG; p++) begin : g_slot
        assign word[p*TW +: TW] = tags[p];
    end
endmodule

// File: rtl/fstack_ctrl.sv
module fstack_ctrl
    import fstack_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int DW     = 80,
    parameter int SWW    = 16,
    parameter int TOP_LSB = 11,
    localparam int PW    = $clog2(NREG),
    localparam int TW    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic [PW-1:0]     cmd_idx,
    input  logic [DW-1:0]     cmd_data,
    input  logic [TW-1:0]     cmd_tag,
    input  logic [PW-1:0]     rd_idx,
    output logic [DW-1:0]     rd_data,
    output logic [TW-1:0]     rd_tag,
    output logic [PW-1:0]     top,
    output logic [NREG*TW-1:0] tag_word,
    input  logic [SWW-1:0]    sw_in,
    output logic [SWW-1:0]    sw_out
);
    typedef struct packed {
        logic [PW-1:0]             top;
        logic [NREG-1:0][TW-1:0]   tag;
        logic [NREG-1:0][DW-1:0]   val;
    } st_t;

    st_t st_d, st_q;

    logic [PW-1:0] cmd_phys;
    logic [PW-1:0] rd_phys;
    logic [PW-1:0] top_dn;
    logic [PW-1:0] top_up;

    fstack_idx #(.PW(PW)) u_cmd_idx (.base(st_q.top), .rel(cmd_idx), .phys(cmd_phys));
    fstack_idx #(.PW(PW)) u_rd_idx  (.base(st_q.top), .rel(rd_idx),  .phys(rd_phys));

    fstack_tagpack #(.NREG(NREG), .TW(TW)) u_pack (.tags(st_q.tag), .word(tag_word));

    assign top_dn = st_q.top - PW'(1);
    assign top_up = st_q.top + PW'(1);

    always_comb begin
        st_d = st_q;
        if (cmd_valid) begin
            case (cmd_op)
                OP_PUSH: begin
                    st_d.top         = top_dn;
                    st_d.val[top_dn] = cmd_data;
                    st_d.tag[top_dn] = cmd_tag;
                end
                OP_PUSH_ST: begin
                    // source index uses the pointer before it moves
                    st_d.top         = top_dn;
                    st_d.val[top_dn] = st_q.val[cmd_phys];
                    st_d.tag[top_dn] = st_q.tag[cmd_phys];
                end
                OP_POP: begin
                    st_d.tag[st_q.top] = TAG_EMPTY;
                    st_d.top           = top_up;
                end
                OP_XCHG: begin
                    st_d.val[st_q.top] = st_q.val[cmd_phys];
                    st_d.val[cmd_phys] = st_q.val[st_q.top];
                    st_d.tag[st_q.top] = st_q.tag[cmd_phys];
                    st_d.tag[cmd_phys] = st_q.tag[st_q.top];
                end
                OP_FREE: begin
                    st_d.tag[cmd_phys] = TAG_EMPTY;
                end
                OP_FREE_POP: begin
                    st_d.tag[cmd_phys] = TAG_EMPTY;
                    st_d.tag[st_q.top] = TAG_EMPTY;
                    st_d.top           = top_up;
                end
                OP_INCP: st_d.top = top_up;
                OP_DECP: st_d.top = top_dn;
                OP_INIT: begin
                    st_d.top = '0;
                    for (int p = 0; p < NREG; p++) st_d.tag[p] = TAG_EMPTY;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.top <= '0;
            for (int p = 0; p < NREG; p++) begin
                st_q.tag[p] <= TAG_EMPTY;
                st_q.val[p] <= '0;
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign top     = st_q.top;
    assign rd_data = st_q.val[rd_phys];
    assign rd_tag  = st_q.tag[rd_phys];

    always_comb begin
        sw_out = sw_in;
        sw_out[TOP_LSB +: PW] = st_q.top;
    end

    // R8
    incp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_INCP) |=> (top == PW'($past(top) + PW'(1))) && $stable(tag_word));

    // R8
    decp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DECP) |=> (top == PW'($past(top) - PW'(1))) && $stable(tag_word));

    // R5
    pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_POP) |=> (top == PW'($past(top) + PW'(1))) && (st_q.tag[$past(top)] == TAG_EMPTY));

    // R12
    init_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_INIT) |=> (top == '0) && (&tag_word));

    // R7
    free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_FREE) |=> $stable(top));

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid) |=> $stable(top) && $stable(tag_word) && $stable(st_q.val));

    // R3
    push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PUSH) |=> (top == PW'($past(top) - PW'(1))) && (st_q.val[top] == $past(cmd_data)));
endmodule

// File: tb/fstack_ctrl_tb_top.sv
`timescale 1ns/1ps
module fstack_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic [79:0] cmd_data = '0;
    logic [1:0]  cmd_tag = '0;
    logic [2:0]  rd_idx = '0;
    logic [79:0] rd_data;
    logic [1:0]  rd_tag;
    logic [2:0]  top;
    logic [15:0] tag_word;
    logic [15:0] sw_in = '0;
    logic [15:0] sw_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int          mtop;
    logic [1:0]  mtag [8];
    logic [79:0] mval [8];

    always #2 clk = ~clk;

    fstack_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_idx(cmd_idx), .cmd_data(cmd_data), .cmd_tag(cmd_tag),
        .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag), .top(top),
        .tag_word(tag_word), .sw_in(sw_in), .sw_out(sw_out)
    );

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            4: return "R6";
            5, 6: return "R7";
            7, 8: return "R8";
            9: return "R12";
            default: return "R11";
        endcase
    endfunction

    // compare every observable against the model
    task automatic check_all(input string req);
        logic [15:0] ew;
        ew = '0;
        for (int p = 0; p < 8; p++) ew[2*p +: 2] = mtag[p];
        chk({req, " top"}, 80'(top), 80'(mtop));
        // R9
        chk({req, " R9 tag_word"}, 80'(tag_word), 80'(ew));
        // R10
        chk({req, " R10 sw_out"}, 80'(sw_out), 80'({sw_in[15:14], 3'(mtop), sw_in[10:0]}));
        for (int i = 0; i < 8; i++) begin
            rd_idx = 3'(i);
            #0.4;
            // R2
            chk({req, " R2 rd_data"}, rd_data, mval[(mtop + i) % 8]);
            chk({req, " R2 rd_tag"}, 80'(rd_tag), 80'(mtag[(mtop + i) % 8]));
        end
    endtask

    task automatic model(input bit v, input int op, input int idx, input logic [79:0] d, input logic [1:0] t);
        int ph, dn, up;
        logic [79:0] tv;
        logic [1:0]  tt;
        ph = (mtop + idx) % 8;
        dn = (mtop + 7) % 8;
        up = (mtop + 1) % 8;
        if (!v) return;
        case (op)
            1: begin mtop = dn; mval[dn] = d; mtag[dn] = t; end
            2: begin tv = mval[ph]; tt = mtag[ph]; mtop = dn; mval[dn] = tv; mtag[dn] = tt; end
            3: begin mtag[mtop] = 2'b11; mtop = up; end
            4: begin
                tv = mval[mtop]; tt = mtag[mtop];
                mval[mtop] = mval[ph]; mtag[mtop] = mtag[ph];
                mval[ph] = tv; mtag[ph] = tt;
            end
            5: mtag[ph] = 2'b11;
            6: begin mtag[ph] = 2'b11; mtag[mtop] = 2'b11; mtop = up; end
            7: mtop = up;
            8: mtop = dn;
            9: begin mtop = 0; for (int p = 0; p < 8; p++) mtag[p] = 2'b11; end
            default: ;
        endcase
    endtask

    task automatic do_op(input bit v, input int op, input int idx, input logic [79:0] d, input logic [1:0] t);
        @(negedge clk);
        cmd_valid = v; cmd_op = 4'(op); cmd_idx = 3'(idx); cmd_data = d; cmd_tag = t;
        sw_in = 16'(d[15:0] ^ 16'h5a5a);
        @(posedge clk);
        #0.5;
        cmd_valid = 1'b0;
        model(v, op, idx, d, t);
        check_all(v ? req_of(op) : "R11");
    endtask

    initial begin
        mtop = 0;
        for (int p = 0; p < 8; p++) begin mtag[p] = 2'b11; mval[p] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        check_all("R1");
        // fill the stack to give distinct contents
        for (int k = 0; k < 8; k++)
            do_op(1'b1, 1, 0, {16'hF00 + 16'(k), 64'h1234_5678_9ABC_0000 + 64'(k)}, 2'(k % 3));
        // near-exhaustive sweep of opcode x index, several rounds
        for (int r = 0; r < 4; r++) begin
            for (int op = 0; op < 16; op++) begin
                for (int idx = 0; idx < 8; idx++) begin
                    logic [79:0] d;
                    d = {16'(r * 256 + op * 16 + idx), 64'hA5C3_0000_0000_0000 ^ 64'((r * 128 + op * 8 + idx) * 7919)};
                    if (op == 0) begin
                        // R11: strobe low with a real opcode
                        do_op(1'b0, (idx % 9) + 1, idx, d, 2'(idx % 3));
                        do_op(1'b1, 0, idx, d, 2'(idx % 3));
                    end else if (op == 9 && idx != 7) begin
                        do_op(1'b1, 1, idx, d, 2'(idx % 3));
                    end else begin
                        do_op(1'b1, op, idx, d, 2'((op + idx) % 3));
                    end
                end
            end
        end
        // R10: status merge across every pointer value
        for (int k = 0; k < 8; k++) do_op(1'b1, 8, 0, {64'h0, 16'hFFFF}, 2'b00);
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #150000;
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog R11 act=hung exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule